// File: doc/BRIEF.md
# Framed Serial Audio Word Receiver

This block turns a time-slotted serial audio stream into parallel words. It watches a bit clock, a frame-sync strobe and a serial data line, all sampled in the system clock domain. A frame starts on the leading edge of the active frame-sync level. The receiver then counts bits into words of a configurable length and words into numbered slots, up to a configurable final slot. Each completed word in a slot that is not masked is reformatted and offered on a valid/ready output. Reformatting covers alignment inside the output word and an optional sign fill.

The sync may coincide with the first data bit or lead it by one bit clock, and it may be active high or active low. Bits are taken on either bit-clock edge, in MSB-first or LSB-first order. A live flag shows when the final slot of the frame is being received. Each delivered word carries a flag that marks it as the word received while the frame sync occurred. A word that completes while the previous one is still waiting is dropped, and a sticky overrun flag records the loss. Dropping `en` idles the receiver and clears the flag.

Top module: `serial_slot_rx`

## Requirements
- R1: While `en` is low, and after reset, `out_valid`, `overrun` and `last_slot_now` are 0. Lowering `en` clears a set overrun flag.
- R2: With `cfg_early_fs`=0, the bit sampled together with the leading edge of the active frame sync is the first data bit of slot 0.
- R3: With `cfg_early_fs`=1, the sync is seen one bit clock ahead. The bit sampled with the sync edge is discarded and the next bit is the first data bit.
- R4: `cfg_fs_low`=0 treats a high `fsync` as active, and `cfg_fs_low`=1 treats a low `fsync` as active.
- R5: `cfg_rise`=0 samples `sdata` and `fsync` on falling edges of `bclk`, and `cfg_rise`=1 samples them on rising edges.
- R6: `cfg_lsb_first`=0 takes the first received bit as the word's MSB, and `cfg_lsb_first`=1 takes it as the LSB.
- R7: With `cfg_lsb_align`=1 the word occupies bits `cfg_wlen`-1..0. With `cfg_lsb_align`=0 its top bit lands on bit 31 when `cfg_wlen` >= 16, and on bit 15 when `cfg_wlen` < 16. Unused bits below the word are 0.
- R8: With `cfg_sext`=1, every output bit above the word's top bit equals the word's top bit. With `cfg_sext`=0, those bits are 0.
- R9: When bit n of `slot_mask` is 1, slot n yields no output word. Its bits still advance the slot count.
- R10: `last_slot_now` is 1 while slot number `cfg_last_slot` is being received, and 0 in every other slot.
- R11: `out_fs_seen` is 1 with the word from slot 0 and 0 with all other words.
- R12: While `out_valid`=1 and `out_ready`=0, `out_data` holds. A further completed word is dropped and `overrun` sets and stays set.
- R13: After the word of slot `cfg_last_slot` completes, incoming bits are ignored until the next frame-sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; low idles and clears state |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame-sync strobe |
| sdata | input | 1 | Serial data |
| cfg_early_fs | input | 1 | 1: sync leads first data bit by one bit |
| cfg_fs_low | input | 1 | 1: frame sync active low |
| cfg_rise | input | 1 | 1: sample on rising bclk edge, 0: falling |
| cfg_lsb_first | input | 1 | 1: first bit is LSB |
| cfg_lsb_align | input | 1 | 1: word placed from bit 0 |
| cfg_sext | input | 1 | 1: fill upper bits with word's top bit |
| cfg_wlen | input | 6 | Word length in bits (2..32) |
| cfg_last_slot | input | 5 | Number of the final slot in a frame |
| slot_mask | input | 32 | Bit n set: slot n skipped |
| out_data | output | 32 | Formatted received word |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts word |
| out_fs_seen | output | 1 | Word was received at frame sync (slot 0) |
| last_slot_now | output | 1 | Final slot of frame in progress |
| overrun | output | 1 | Sticky: a word was dropped |

## Verification
The bench targets the one-bit offset of early sync. A receiver that got it wrong would return every word shifted by one bit. It checks short words, which must sit at bit 15 rather than bit 31, so that a wrong length split puts them in the wrong half. It also checks sign fill with both alignments, where a design filling from the wrong bit corrupts the word or leaves stale zeros. Masked slots must still advance the count, so that the last-slot flag marks the right slot and no extra word appears. Bits after the final slot must not start a phantom word. A stalled consumer must see its held word unchanged while a later word is dropped and overrun set.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   typedef struct packed {
      logic early_fs;
      logic fs_low;
      logic rise;
      logic lsb_first;
      logic lsb_align;
      logic sext;
   } rx_cfg_t;
endpackage

// File: rtl/rxs_edge.sv
module rxs_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic fsync,
   input  logic sdata,
   input  logic rise,
   output logic tick,
   output logic fs_s,
   output logic sd_s
);
   logic [2:0] pins;
   logic       bclk_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pins = {bclk, fsync, sdata};
      end else begin : g_sync
         logic [2:0] chain [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
            end else begin
               chain[0] <= {bclk, fsync, sdata};
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign pins = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= pins[2];
   end

   assign tick = rise ? (pins[2] & ~bclk_q) : (~pins[2] & bclk_q);
   assign fs_s = pins[1];
   assign sd_s = pins[0];
endmodule

// File: rtl/rxs_framer.sv
module rxs_framer import rxs_pkg::*; #(
   parameter int DATA_W    = 32,
   parameter int MAX_SLOTS = 32,
   parameter int LEN_W     = 6,
   parameter int SLOT_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 tick,
   input  logic                 sd,
   input  logic                 fs,
   input  rx_cfg_t              cfg,
   input  logic [LEN_W-1:0]     wlen,
   input  logic [SLOT_W-1:0]    last_idx,
   input  logic [MAX_SLOTS-1:0] slot_mask,
   output logic                 done_o,
   output logic [DATA_W-1:0]    raw_o,
   output logic                 first_o,
   output logic                 last_now_o
);
   logic              active, fs_prev, fs_act, start, take, fin;
   logic [LEN_W-1:0]  bit_idx, pos;
   logic [SLOT_W-1:0] slot_idx, slot;
   logic [DATA_W-1:0] acc_q, acc, nxt;

   always_comb begin
      fs_act = fs ^ cfg.fs_low;
      start  = tick & fs_act & ~fs_prev;
      take   = tick & (start ? ~cfg.early_fs : active);
      pos    = start ? '0 : bit_idx;
      slot   = start ? '0 : slot_idx;
      acc    = start ? '0 : acc_q;
      nxt    = cfg.lsb_first ? (acc | (DATA_W'(sd) << pos))
                             : {acc[DATA_W-2:0], sd};
      fin    = take & (pos == wlen - LEN_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0; fs_prev <= 1'b0; bit_idx <= '0;
         slot_idx <= '0; acc_q <= '0;
      end else if (!en) begin
         active <= 1'b0; fs_prev <= 1'b0; bit_idx <= '0;
         slot_idx <= '0; acc_q <= '0;
      end else if (tick) begin
         fs_prev <= fs_act;
         if (start && cfg.early_fs) begin
            active <= 1'b1; bit_idx <= '0; slot_idx <= '0; acc_q <= '0;
         end else if (take) begin
            if (fin) begin
               acc_q    <= '0;
               bit_idx  <= '0;
               slot_idx <= slot + SLOT_W'(1);
               active   <= (slot != last_idx);
            end else begin
               acc_q    <= nxt;
               bit_idx  <= pos + LEN_W'(1);
               slot_idx <= slot;
               active   <= 1'b1;
            end
         end
      end
   end

   assign done_o     = fin & ~slot_mask[slot];
   assign raw_o      = nxt;
   assign first_o    = (slot == '0);
   assign last_now_o = active & (slot_idx == last_idx);

   // R13
   frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && fin && slot == last_idx) |=> !last_now_o);
endmodule

// File: rtl/rxs_format.sv
module rxs_format #(
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 6,
   parameter bit SEXT_EN = 1'b1
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [LEN_W-1:0]  wlen,
   input  logic              lsb_align,
   input  logic              sext,
   output logic [DATA_W-1:0] data
);
   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] lo_mask, r, v, hi_mask;
   logic [LEN_W-1:0]  top_b, sh_b;
   logic              sign;

   always_comb begin
      lo_mask = {DATA_W{1'b1}} >> (DATA_W - int'(wlen));
      r       = raw & lo_mask;
      sign    = |(r & ~(lo_mask >> 1));
      if (lsb_align)                top_b = wlen - LEN_W'(1);
      else if (int'(wlen) < HALF)   top_b = LEN_W'(HALF - 1);
      else                          top_b = LEN_W'(DATA_W - 1);
      sh_b    = top_b + LEN_W'(1) - wlen;
      v       = r << sh_b;
      hi_mask = ~({DATA_W{1'b1}} >> (DATA_W - 1 - int'(top_b)));
   end

   generate
      if (SEXT_EN) begin : g_sext
         assign data = v | ((sext && sign) ? hi_mask : '0);
      end else begin : g_plain
         logic unused_sext;
         assign unused_sext = sext ^ sign ^ (|hi_mask);
         assign data = v;
      end
   endgenerate
endmodule

// File: rtl/serial_slot_rx.sv
module serial_slot_rx import rxs_pkg::*; #(
   parameter int DATA_W      = 32,
   parameter int MAX_SLOTS   = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit SEXT_EN     = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        bclk,
   input  logic        fsync,
   input  logic        sdata,
   input  logic        cfg_early_fs,
   input  logic        cfg_fs_low,
   input  logic        cfg_rise,
   input  logic        cfg_lsb_first,
   input  logic        cfg_lsb_align,
   input  logic        cfg_sext,
   input  logic [$clog2(DATA_W+1)-1:0] cfg_wlen,
   input  logic [$clog2(MAX_SLOTS)-1:0] cfg_last_slot,
   input  logic [MAX_SLOTS-1:0] slot_mask,
   output logic [DATA_W-1:0] out_data,
   output logic        out_valid,
   input  logic        out_ready,
   output logic        out_fs_seen,
   output logic        last_slot_now,
   output logic        overrun
);
   localparam int LEN_W  = $clog2(DATA_W + 1);
   localparam int SLOT_W = $clog2(MAX_SLOTS);

   generate
      if (DATA_W < 16 || DATA_W % 2 != 0) begin : g_bad_width
         $error("DATA_W must be even and at least 16");
      end
      if (MAX_SLOTS < 2 || (MAX_SLOTS & (MAX_SLOTS - 1)) != 0) begin : g_bad_slots
         $error("MAX_SLOTS must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   rx_cfg_t           cfg;
   logic              tick, fs_s, sd_s, done, first;
   logic [DATA_W-1:0] raw, fmt;

   assign cfg = '{early_fs: cfg_early_fs, fs_low: cfg_fs_low, rise: cfg_rise,
                  lsb_first: cfg_lsb_first, lsb_align: cfg_lsb_align, sext: cfg_sext};

   rxs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
      .rise(cfg_rise), .tick(tick), .fs_s(fs_s), .sd_s(sd_s));

   rxs_framer #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .LEN_W(LEN_W), .SLOT_W(SLOT_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .sd(sd_s), .fs(fs_s),
      .cfg(cfg), .wlen(cfg_wlen), .last_idx(cfg_last_slot), .slot_mask(slot_mask),
      .done_o(done), .raw_o(raw), .first_o(first), .last_now_o(last_slot_now));

   rxs_format #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SEXT_EN(SEXT_EN)) u_format (
      .raw(raw), .wlen(cfg_wlen), .lsb_align(cfg_lsb_align), .sext(cfg_sext),
      .data(fmt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0; out_data <= '0; out_fs_seen <= 1'b0; overrun <= 1'b0;
      end else if (!en) begin
         out_valid <= 1'b0; overrun <= 1'b0;
      end else if (done) begin
         if (out_valid && !out_ready) begin
            overrun <= 1'b1;
         end else begin
            out_valid   <= 1'b1;
            out_data    <= fmt;
            out_fs_seen <= first;
         end
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R12
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   // R12
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && overrun) |=> overrun);
   // R12
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(out_valid && !out_ready));
   // R1
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!out_valid && !overrun && !last_slot_now));
endmodule

// File: tb/test_serial_slot_rx.sv
module test_serial_slot_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        bclk = 1'b1, fsync = 1'b0, sdata = 1'b0;
   logic        cfg_early_fs = 0, cfg_fs_low = 0, cfg_rise = 0;
   logic        cfg_lsb_first = 0, cfg_lsb_align = 0, cfg_sext = 0;
   logic [5:0]  cfg_wlen = 6'd16;
   logic [4:0]  cfg_last_slot = 5'd1;
   logic [31:0] slot_mask = '0;
   logic [31:0] out_data;
   logic        out_valid, out_ready = 1'b1, out_fs_seen, last_slot_now, overrun;

   int checks = 0, errors = 0;
   logic finished = 1'b0;

   logic [31:0] tx_w   [0:7];
   logic [31:0] got_d  [0:63];
   logic        got_fs [0:63];
   logic        ls_seen[0:7];
   int          got_n = 0;

   always #10 clk = ~clk;

   serial_slot_rx i_serial_slot_rx (
      .clk(clk), .rst_n(rst_n), .en(en), .bclk(bclk), .fsync(fsync), .sdata(sdata),
      .cfg_early_fs(cfg_early_fs), .cfg_fs_low(cfg_fs_low), .cfg_rise(cfg_rise),
      .cfg_lsb_first(cfg_lsb_first), .cfg_lsb_align(cfg_lsb_align), .cfg_sext(cfg_sext),
      .cfg_wlen(cfg_wlen), .cfg_last_slot(cfg_last_slot), .slot_mask(slot_mask),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_fs_seen(out_fs_seen), .last_slot_now(last_slot_now), .overrun(overrun));

   always @(negedge clk) begin
      if (out_valid && out_ready && got_n < 64) begin
         got_d[got_n]  = out_data;
         got_fs[got_n] = out_fs_seen;
         got_n = got_n + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_fmt(input logic [31:0] w, input int wl,
                                               input logic la, input logic sx);
      logic [31:0] r, v;
      int top, sh;
      r = w & (32'hFFFF_FFFF >> (32 - wl));
      top = la ? wl - 1 : (wl < 16 ? 15 : 31);
      sh = top + 1 - wl;
      v = r << sh;
      if (sx && r[wl-1])
         for (int i = top + 1; i < 32; i++) v[i] = 1'b1;
      return v;
   endfunction

   task automatic send_bit(input logic d, input logic fs_on);
      @(negedge clk);
      bclk  = cfg_rise ? 1'b0 : 1'b1;
      sdata = d;
      fsync = fs_on ^ cfg_fs_low;
      repeat (4) @(negedge clk);
      bclk = ~bclk;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(input int nslots, input int wl);
      send_bit(1'b0, 1'b0);
      send_bit(1'b0, 1'b0);
      if (cfg_early_fs) send_bit(1'b1, 1'b1);
      for (int s = 0; s < nslots; s++) begin
         for (int b = 0; b < wl; b++) begin
            send_bit(cfg_lsb_first ? tx_w[s][b] : tx_w[s][wl-1-b],
                     !cfg_early_fs && s == 0 && b == 0);
            if (b == 1) ls_seen[s] = last_slot_now;
         end
      end
      send_bit(1'b0, 1'b0);
      send_bit(1'b0, 1'b0);
   endtask

   task automatic set_cfg(input logic e, input logic fl, input logic ri, input logic lf,
                          input logic la, input logic sx, input int wl, input int last);
      @(negedge clk);
      cfg_early_fs = e; cfg_fs_low = fl; cfg_rise = ri; cfg_lsb_first = lf;
      cfg_lsb_align = la; cfg_sext = sx; cfg_wlen = 6'(wl); cfg_last_slot = 5'(last);
      bclk = ri ? 1'b0 : 1'b1;
      fsync = fl;
      repeat (6) @(negedge clk);
      got_n = 0;
   endtask

   task automatic t_reset;
      check("R1 valid after reset", 32'(out_valid), 32'd0);
      check("R1 overrun after reset", 32'(overrun), 32'd0);
      check("R1 last slot after reset", 32'(last_slot_now), 32'd0);
   endtask

   task automatic t_msb_falling;
      set_cfg(0, 0, 0, 0, 0, 0, 16, 1);
      slot_mask = '0;
      tx_w[0] = 32'hA5C3; tx_w[1] = 32'h1234;
      send_frame(2, 16);
      check("R2 word count", 32'(got_n), 32'd2);
      check("R2 R5 R7 slot0 word", got_d[0], 32'hA5C3_0000);
      check("R7 slot1 word", got_d[1], 32'h1234_0000);
      check("R11 fs flag slot0", 32'(got_fs[0]), 32'd1);
      check("R11 fs flag slot1", 32'(got_fs[1]), 32'd0);
   endtask

   task automatic t_early_low_rise;
      set_cfg(1, 1, 1, 0, 1, 0, 24, 1);
      tx_w[0] = 32'h12_3456; tx_w[1] = 32'h80_0001;
      send_frame(2, 24);
      check("R3 R4 word count", 32'(got_n), 32'd2);
      check("R3 R4 R5 early sync word", got_d[0], 32'h0012_3456);
      check("R7 R8 lsb aligned no fill", got_d[1], 32'h0080_0001);
   endtask

   task automatic t_lsb_first_sext;
      set_cfg(0, 0, 0, 1, 0, 1, 12, 0);
      tx_w[0] = 32'h9AB;
      send_frame(1, 12);
      check("R6 R7 R8 short msb-aligned filled",
            got_d[0], expect_fmt(32'h9AB, 12, 1'b0, 1'b1));
      set_cfg(0, 0, 1, 1, 1, 1, 12, 1);
      tx_w[0] = 32'h801; tx_w[1] = 32'h3C5;
      send_frame(2, 12);
      check("R8 lsb-aligned negative", got_d[0], 32'hFFFF_F801);
      check("R8 lsb-aligned positive", got_d[1], 32'h0000_03C5);
   endtask

   task automatic t_mask_last;
      set_cfg(0, 0, 0, 0, 0, 0, 16, 3);
      slot_mask = 32'b1010;
      tx_w[0] = 32'h1111; tx_w[1] = 32'h2222; tx_w[2] = 32'h3333; tx_w[3] = 32'h4444;
      send_frame(4, 16);
      check("R9 words from unmasked slots", 32'(got_n), 32'd2);
      check("R9 first kept word", got_d[0], 32'h1111_0000);
      check("R9 second kept word", got_d[1], 32'h3333_0000);
      check("R11 fs flag on later slot", 32'(got_fs[1]), 32'd0);
      check("R10 flag in slot 0", 32'(ls_seen[0]), 32'd0);
      check("R10 flag in slot 2", 32'(ls_seen[2]), 32'd0);
      check("R10 flag in last slot", 32'(ls_seen[3]), 32'd1);
      slot_mask = '0;
   endtask

   task automatic t_frame_end;
      set_cfg(0, 0, 0, 0, 0, 0, 8, 0);
      tx_w[0] = 32'h5A; tx_w[1] = 32'hFF;
      send_frame(1, 8);
      for (int b = 0; b < 8; b++) send_bit(1'b1, 1'b0);
      repeat (10) @(negedge clk);
      check("R13 no word after final slot", 32'(got_n), 32'd1);
      check("R13 R7 short word position", got_d[0], 32'h0000_5A00);
      check("R13 idle last flag", 32'(last_slot_now), 32'd0);
   endtask

   task automatic t_overrun;
      set_cfg(0, 0, 0, 0, 0, 0, 8, 1);
      out_ready = 1'b0;
      tx_w[0] = 32'h11; tx_w[1] = 32'h22;
      send_frame(2, 8);
      check("R12 word held valid", 32'(out_valid), 32'd1);
      check("R12 held data is first word", out_data, 32'h0000_1100);
      check("R12 overrun set", 32'(overrun), 32'd1);
      @(negedge clk); out_ready = 1'b1;
      repeat (3) @(negedge clk);
      check("R12 only first word delivered", 32'(got_n), 32'd1);
      check("R12 overrun stays set", 32'(overrun), 32'd1);
      en = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 disable clears overrun", 32'(overrun), 32'd0);
      en = 1'b1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      en = 1'b1;
      t_msb_falling();
      t_early_low_rise();
      t_lsb_first_sext();
      t_mask_last();
      t_frame_end();
      t_overrun();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule